// File: doc/BRIEF.md
# Cache Address Filter Router

This block stands between the outer cache of a processor and two downstream request ports. Every outgoing request carries a 32-bit physical address. The block compares that address against a programmable window whose bounds are held in 1 MiB units. A request whose address falls inside the window goes to the memory-controller port, M1. Every other request goes to the interconnect port, M0. The window is half-open: its lower bound is inclusive and its upper bound is exclusive. A filter enable flag is stored in the same register as the lower bound. When the flag is clear, the window is empty.

The request side is a valid/ready stream with one upstream port and two downstream ports. Exactly one downstream valid follows the upstream valid. The upstream ready is the ready of the port that was chosen. After the source raises `req_valid`, it must hold both `req_valid` and `req_addr` steady until the handshake completes. While a request is stalled by back-pressure, the port chosen for it stays fixed, even if software reprograms the window in the meantime. The two bound registers sit on a plain 32-bit register bus. Writes to this bus take one cycle to take effect. Reads from it are combinational.

Top module: `cache_addr_filter_router`

## Requirements
- R1: After reset, the lower-bound register (offset 0xC00) reads 0x0010_0001: the bound is 1 MiB and the enable flag in bit 0 is 1. The upper-bound register (offset 0xC04) reads 0xC000_0000.
- R2: Reserved bits read as zero, and writes to them have no effect. The reserved bits are bits 19..1 of the lower-bound register and bits 19..0 of the upper-bound register. For example, writing 0xFFFF_FFFF to each register gives read values of 0xFFF0_0001 and 0xFFF0_0000.
- R3: Only offsets 0xC00 and 0xC04 are mapped. Any other offset reads as zero, and a write to it leaves both registers unchanged.
- R4: While the enable flag is set, a request whose address satisfies lower <= address < upper is steered to M1. The comparison uses address bits 31..20 against register bits 31..20.
- R5: While the enable flag is clear, every request is steered to M0. A request outside the window is also steered to M0 when the flag is set.
- R6: When lower >= upper, no address is inside the window, and all requests go to M0.
- R7: Exactly one of `m0_valid` and `m1_valid` is high while `req_valid` is high, and neither is high otherwise. The chosen port receives `req_addr` unchanged. `req_ready` equals the ready of the chosen port.
- R8: A register write performed in cycle N governs requests first presented in cycle N+1 or later. A request presented in cycle N uses the old values. A request stalled by back-pressure keeps the port chosen when it was first presented until its handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request ready |
| req_addr | input | 32 | Upstream physical address |
| m0_valid | output | 1 | Interconnect port valid |
| m0_ready | input | 1 | Interconnect port ready |
| m0_addr | output | 32 | Interconnect port address |
| m1_valid | output | 1 | Memory-controller port valid |
| m1_ready | input | 1 | Memory-controller port ready |
| m1_addr | output | 32 | Memory-controller port address |

## Verification
Two events can land in the same cycle: a register write, and either the arrival of a request or a stall that is still pending. The bench provokes the first case by driving a write that disables the filter in the same cycle as a fresh in-window request. The scoreboard must then see that request on M1, and the next request on M0. The bench provokes the second case by holding `m1_ready` low on an in-window request while the filter is disabled. The request must stay on M1 until it is released, and only the request that follows moves to M0.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int unsigned REG_DW = 32;

  typedef enum logic {
    PORT_IC  = 1'b0,
    PORT_MEM = 1'b1
  } route_e;
endpackage

// File: rtl/afr_regs.sv
module afr_regs #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_LOG2 = 20,
  parameter int unsigned REG_AW    = 12,
  parameter logic [REG_AW-1:0] LO_OFS = 12'hC00,
  parameter logic [REG_AW-1:0] HI_OFS = 12'hC04,
  parameter logic [ADDR_W-1:0] LO_RST = 32'h0010_0000,
  parameter logic              EN_RST = 1'b1,
  parameter logic [ADDR_W-1:0] HI_RST = 32'hC000_0000,
  localparam int unsigned FIELD_W = ADDR_W - GRAN_LOG2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wen,
  input  logic [REG_AW-1:0]          addr,
  input  logic [afr_pkg::REG_DW-1:0] wdata,
  output logic [afr_pkg::REG_DW-1:0] rdata,
  output logic [FIELD_W-1:0]         lo_field,
  output logic [FIELD_W-1:0]         hi_field,
  output logic                       enable
);
  logic [FIELD_W-1:0] lo_q, hi_q;
  logic               en_q;
  logic               unused_resv;

  assign unused_resv = ^wdata[GRAN_LOG2-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= LO_RST[ADDR_W-1:GRAN_LOG2];
      en_q <= EN_RST;
      hi_q <= HI_RST[ADDR_W-1:GRAN_LOG2];
    end else if (wen) begin
      if (addr == LO_OFS) begin
        lo_q <= wdata[ADDR_W-1:GRAN_LOG2];
        en_q <= wdata[0];
      end else if (addr == HI_OFS) begin
        hi_q <= wdata[ADDR_W-1:GRAN_LOG2];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == LO_OFS) begin
      rdata[ADDR_W-1:GRAN_LOG2] = lo_q;
      rdata[0]                  = en_q;
    end else if (addr == HI_OFS) begin
      rdata[ADDR_W-1:GRAN_LOG2] = hi_q;
    end
  end

  assign lo_field = lo_q;
  assign hi_field = hi_q;
  assign enable   = en_q;

  // R2: reserved bits never read back as ones
  assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == LO_OFS) |-> (rdata[GRAN_LOG2-1:1] == '0));
  assert_resv_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == HI_OFS) |-> (rdata[GRAN_LOG2-1:0] == '0));
  // R3: unmapped offsets read as zero and leave the registers alone
  assert_unmapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != LO_OFS && addr != HI_OFS) |-> (rdata == '0));
  assert_unmapped_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr != LO_OFS && addr != HI_OFS) |=>
      ($stable(lo_q) && $stable(hi_q) && $stable(en_q)));
  // R1: values right after reset release
  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lo_q == LO_RST[ADDR_W-1:GRAN_LOG2] && en_q == EN_RST &&
                      hi_q == HI_RST[ADDR_W-1:GRAN_LOG2]));
endmodule

// File: rtl/afr_window_cmp.sv
module afr_window_cmp #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_LOG2 = 20,
  localparam int unsigned FIELD_W = ADDR_W - GRAN_LOG2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FIELD_W-1:0] lo_field,
  input  logic [FIELD_W-1:0] hi_field,
  input  logic               enable,
  output afr_pkg::route_e    route
);
  logic [FIELD_W-1:0] page;
  logic               ge_lo, lt_hi;
  logic               unused_low;

  assign page       = addr[ADDR_W-1:GRAN_LOG2];
  assign unused_low = ^addr[GRAN_LOG2-1:0];
  assign ge_lo      = (page >= lo_field);
  assign lt_hi      = (page <  hi_field);
  assign route      = (enable && ge_lo && lt_hi) ? afr_pkg::PORT_MEM : afr_pkg::PORT_IC;
endmodule

// File: rtl/afr_route_hold.sv
module afr_route_hold (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  afr_pkg::route_e fresh_route,
  input  logic            m0_ready,
  input  logic            m1_ready,
  output afr_pkg::route_e cur_route,
  output logic            held,
  output logic            req_ready,
  output logic            m0_valid,
  output logic            m1_valid
);
  afr_pkg::route_e held_route_q;
  logic            held_q;

  assign held      = held_q;
  assign cur_route = held_q ? held_route_q : fresh_route;
  assign req_ready = (cur_route == afr_pkg::PORT_MEM) ? m1_ready : m0_ready;
  assign m1_valid  = req_valid && (cur_route == afr_pkg::PORT_MEM);
  assign m0_valid  = req_valid && (cur_route == afr_pkg::PORT_IC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q       <= 1'b0;
      held_route_q <= afr_pkg::PORT_IC;
    end else begin
      held_q       <= req_valid && !req_ready;
      held_route_q <= cur_route;
    end
  end

  // R7: one downstream valid per upstream valid
  assert_one_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m0_valid, m1_valid}) && (req_valid == (m0_valid || m1_valid)));
  // R8: a stalled request keeps its port
  assert_stall_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!req_valid || (m1_valid == $past(m1_valid))));
endmodule

// File: rtl/cache_addr_filter_router.sv
module cache_addr_filter_router #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_LOG2 = 20,
  parameter int unsigned REG_AW    = 12,
  parameter logic [REG_AW-1:0] LO_OFS = 12'hC00,
  parameter logic [REG_AW-1:0] HI_OFS = 12'hC04,
  parameter logic [ADDR_W-1:0] LO_RST = 32'h0010_0000,
  parameter logic              EN_RST = 1'b1,
  parameter logic [ADDR_W-1:0] HI_RST = 32'hC000_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wen,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [afr_pkg::REG_DW-1:0] reg_wdata,
  output logic [afr_pkg::REG_DW-1:0] reg_rdata,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       m0_valid,
  input  logic                       m0_ready,
  output logic [ADDR_W-1:0]          m0_addr,
  output logic                       m1_valid,
  input  logic                       m1_ready,
  output logic [ADDR_W-1:0]          m1_addr
);
  localparam int unsigned FIELD_W = ADDR_W - GRAN_LOG2;

  logic [FIELD_W-1:0] lo_field, hi_field;
  logic               enable, held;
  afr_pkg::route_e    fresh_route, cur_route;

  afr_regs #(
    .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .REG_AW(REG_AW),
    .LO_OFS(LO_OFS), .HI_OFS(HI_OFS),
    .LO_RST(LO_RST), .EN_RST(EN_RST), .HI_RST(HI_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .lo_field(lo_field), .hi_field(hi_field), .enable(enable)
  );

  afr_window_cmp #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_cmp (
    .addr(req_addr), .lo_field(lo_field), .hi_field(hi_field),
    .enable(enable), .route(fresh_route)
  );

  afr_route_hold u_hold (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .fresh_route(fresh_route), .m0_ready(m0_ready), .m1_ready(m1_ready),
    .cur_route(cur_route), .held(held), .req_ready(req_ready),
    .m0_valid(m0_valid), .m1_valid(m1_valid)
  );

  assign m0_addr = req_addr;
  assign m1_addr = req_addr;

  // R5: disabled filter sends fresh requests to the interconnect
  assert_disabled_m0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !held && !enable) |-> (m0_valid && !m1_valid));
  // R6: empty window never selects the memory port for a fresh request
  assert_empty_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !held && (lo_field >= hi_field)) |-> !m1_valid);
  // R4: in-window enabled fresh request reaches the memory port
  assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !held && enable &&
     req_addr[ADDR_W-1:GRAN_LOG2] >= lo_field &&
     req_addr[ADDR_W-1:GRAN_LOG2] <  hi_field) |-> (m1_valid && m1_addr == req_addr));
  // R7: ready follows the chosen port
  assert_ready_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_ready == ((cur_route == afr_pkg::PORT_MEM) ? m1_ready : m0_ready)));
endmodule

// File: tb/cache_addr_filter_router_tb.sv
module cache_addr_filter_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        m0_valid, m1_valid;
  logic        m0_ready = 1'b1, m1_ready = 1'b1;
  logic [31:0] m0_addr, m1_addr;

  int n_checks = 0;
  int n_fail   = 0;

  logic [32:0] exp_q[$];     // {port, addr}
  string       tag_q[$];

  logic [11:0] sh_lo = 12'h001, sh_hi = 12'hC00;
  logic        sh_en = 1'b1;

  always #5 clk = ~clk;

  cache_addr_filter_router u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .m0_valid(m0_valid), .m0_ready(m0_ready), .m0_addr(m0_addr),
    .m1_valid(m1_valid), .m1_ready(m1_ready), .m1_addr(m1_addr)
  );

  function automatic logic model_port(input logic [31:0] a);
    return sh_en && (a[31:20] >= sh_lo) && (a[31:20] < sh_hi);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare each completed downstream handshake
  always @(negedge clk) begin
    if (rst_n && ((m0_valid && m0_ready) || (m1_valid && m1_ready))) begin
      logic [32:0] got;
      got = {m1_valid, m1_valid ? m1_addr : m0_addr};
      if (exp_q.size() == 0) begin
        check("R7 unexpected handshake", got[31:0], 32'hXXXX_XXXX);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {31'd0, got[32]}, {31'd0, e[32]});
        check({t, " addr"}, got[31:0], e[31:0]);
      end
    end
  end

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 12'hC00) begin sh_lo = d[31:20]; sh_en = d[0]; end
    else if (a == 12'hC04) sh_hi = d[31:20];
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic reg_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic send(input string tag, input logic [31:0] a);
    exp_q.push_back({model_port(a), a});
    tag_q.push_back(tag);
    req_valid = 1'b1; req_addr = a;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    reg_check("R1 lower reset", 12'hC00, 32'h0010_0001);
    reg_check("R1 upper reset", 12'hC04, 32'hC000_0000);
    reg_check("R3 unmapped read", 12'hC08, 32'h0);

    // R4/R5 boundaries with reset window
    send("R5 below window", 32'h000F_FFFF);
    send("R4 lower bound", 32'h0010_0000);
    send("R4 top of window", 32'hBFFF_FFFF);
    send("R5 upper bound excluded", 32'hC000_0000);
    send("R5 high address", 32'hFFFF_0000);

    // R3: write to unmapped offset leaves registers alone
    reg_write(12'h800, 32'hFFFF_FFFF);
    reg_check("R3 lower untouched", 12'hC00, 32'h0010_0001);
    reg_check("R3 upper untouched", 12'hC04, 32'hC000_0000);

    // R2: reserved bits
    reg_write(12'hC00, 32'hFFFF_FFFF);
    reg_write(12'hC04, 32'hFFFF_FFFF);
    reg_check("R2 lower reserved", 12'hC00, 32'hFFF0_0001);
    reg_check("R2 upper reserved", 12'hC04, 32'hFFF0_0000);

    // R6: empty and inverted windows
    reg_write(12'hC00, 32'h4000_0001);
    reg_write(12'hC04, 32'h4000_0000);
    send("R6 equal bounds", 32'h4000_0000);
    reg_write(12'hC04, 32'h2000_0000);
    send("R6 inverted bounds", 32'h3000_0000);

    // R4 new window, then R5 disable
    reg_write(12'hC00, 32'h2000_0001);
    reg_write(12'hC04, 32'h3000_0000);
    send("R4 programmed window", 32'h2FF0_1234);
    reg_write(12'hC00, 32'h2000_0000);
    send("R5 disabled in range", 32'h2800_0000);
    reg_write(12'hC00, 32'h2000_0001);

    // R8 same cycle: write disabling and fresh request together
    exp_q.push_back({1'b1, 32'h2100_0000});
    tag_q.push_back("R8 request alongside write uses old");
    reg_wen = 1'b1; reg_addr = 12'hC00; reg_wdata = 32'h2000_0000;
    req_valid = 1'b1; req_addr = 32'h2100_0000;
    @(posedge clk); #1;
    reg_wen = 1'b0; req_valid = 1'b0;
    sh_en = 1'b0;
    send("R8 next request uses new", 32'h2100_0000);

    // R8 stall: in-window request held on M1 while filter disabled
    reg_write(12'hC00, 32'h2000_0001);
    m1_ready = 1'b0;
    exp_q.push_back({1'b1, 32'h2200_0000});
    tag_q.push_back("R8 stalled keeps M1");
    req_valid = 1'b1; req_addr = 32'h2200_0000;
    @(posedge clk); #1;
    reg_write(12'hC00, 32'h2000_0000);
    @(negedge clk);
    check("R8 held on M1 after disable", {30'd0, m1_valid, m0_valid}, 32'd2);
    check("R7 ready follows stalled port", {31'd0, req_ready}, 32'd0);
    @(posedge clk); #1;
    m1_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    send("R8 after release goes M0", 32'h2200_0000);

    // R7 back-pressure on M0
    m0_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h7000_0000;
    @(negedge clk);
    check("R7 M0 stall no ready", {31'd0, req_ready}, 32'd0);
    check("R7 M0 valid only", {30'd0, m1_valid, m0_valid}, 32'd1);
    req_valid = 1'b0;
    @(posedge clk); #1;
    m0_ready = 1'b1;
    @(negedge clk);
    check("R7 idle no valid", {30'd0, m1_valid, m0_valid}, 32'd0);

    repeat (3) @(posedge clk);
    check("R7 all expected handshakes seen", exp_q.size(), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule